// File: doc/BRIEF.md
# Interrupting GPIO Port

This block is a general-purpose I/O port of up to sixteen pins behind a simple single-cycle 32-bit register bus. Each pin can be an input or an output. Output pins drive the value held in an output latch. Every pin, in either direction, is sampled through a two-stage synchronizer, and the sampled level can be read back at any time.

Each pin also has an interrupt source, and its trigger is chosen from five modes: falling edge, rising edge, both edges, level low and level high. A pin that is enabled and sees its trigger condition sets a sticky raw status bit, which software clears by writing ones. A per-pin mask, written through separate set and clear registers, hides raw status from the masked view. The OR of all masked bits drives one interrupt line.

The number of pins is a parameter. Storage exists only for implemented pins, so unimplemented bits read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers are addressed by a 4-bit word index: 0 enable, 1 raw status, 2 masked status, 3 status clear, 4 mask set (reads the mask), 5 mask clear, 6 output latch, 7 input level, 8 direction, 9 mode low, 10 mode high, 11 reserved. Bits at and above NPINS in the per-pin registers read as zero and ignore writes.
- R2: A direction bit of 1 makes the pin an output: pin_oe_o follows the direction register and pin_o follows the output latch. Both registers read back what was written.
- R3: Input-level reads return pin_i after two clock edges of synchronization. A read made after only one edge still returns the old level.
- R4: The mode of pin p is a 3-bit field at bit 4*(p mod 8). Pins 0 to 7 use the mode-low register and pins 8 to 15 use mode high. Bit 3 of each slot, and slots of unimplemented pins, read as zero.
- R5: Mode 000 sets status on a falling edge, 001 on a rising edge and 100 on either edge of the synchronized level.
- R6: Mode 010 (level low) and mode 011 (level high) set status in every cycle the level holds, so a clear does not remove status while the level persists.
- R7: A pin whose enable bit is 0 never sets its raw status, whatever its mode or activity.
- R8: Writing 1 to a bit of the clear register clears that pin's raw status. Bits written as 0 leave the status unchanged.
- R9: Writing 1 to a bit of mask set masks that pin, and writing 1 to mask clear unmasks it. Zero bits in either register leave the mask unchanged. The mask does not alter raw status.
- R10: Masked status equals raw status AND NOT mask, and irq_o is the OR of the masked status bits.
- R11: Mode codes 101, 110 and 111 never set status.
- R12: After reset, every register reads zero: all pins are inputs, interrupts are disabled, nothing is masked, every mode is falling edge, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |
| pin_i | input | NPINS | Pin input levels (asynchronous) |
| pin_o | output | NPINS | Output latch value |
| pin_oe_o | output | NPINS | Output enable per pin |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that each bus access lasts one cycle with stable address and data. They also assume pin_i may change at any time, so they make no claim on how many cycles an edge takes to appear, only on what enable, mask and direction writes must cause in the next cycle. The stimulus changes pins and bus signals only at the falling clock edge. It holds every pin level for at least four cycles, so each change crosses the synchronizer once and is detected exactly once. It drives only offsets 0 to 11. The sweep walks every pin of a 12-pin configuration through all eight mode codes, driving both edges and both clears, so both mode registers and the unimplemented upper bits are covered.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned PINS_PER_MODE_REG = 8;

  localparam logic [ADDR_W-1:0] OFS_EN      = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 4'd10;

  localparam logic [2:0] MODE_FALL   = 3'b000;
  localparam logic [2:0] MODE_RISE   = 3'b001;
  localparam logic [2:0] MODE_LVL_LO = 3'b010;
  localparam logic [2:0] MODE_LVL_HI = 3'b011;
  localparam logic [2:0] MODE_BOTH   = 3'b100;

  function automatic logic mode_hit(input logic [2:0] mode, input logic cur, input logic prev);
    logic h;
    case (mode)
      MODE_FALL:   h = prev & ~cur;
      MODE_RISE:   h = cur & ~prev;
      MODE_LVL_LO: h = ~cur;
      MODE_LVL_HI: h = cur;
      MODE_BOTH:   h = cur ^ prev;
      default:     h = 1'b0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPINS-1:0]      level_i,
  input  logic [NPINS-1:0][2:0] mode_i,
  input  logic [NPINS-1:0]      en_i,
  input  logic [NPINS-1:0]      clr_i,
  output logic [NPINS-1:0]      raw_o
);
  logic [NPINS-1:0] prev_q, raw_q, hit;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit[g] = mode_hit(mode_i[g], level_i[g], prev_q[g]);
  end

  // a new hit wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= level_i;
      raw_q  <= (raw_q & ~clr_i) | (en_i & hit);
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NPINS-1:0]      din_i,
  input  logic [NPINS-1:0]      raw_i,
  input  logic [NPINS-1:0]      masked_i,
  output logic [NPINS-1:0]      en_o,
  output logic [NPINS-1:0]      mask_o,
  output logic [NPINS-1:0]      dout_o,
  output logic [NPINS-1:0]      dir_o,
  output logic [NPINS-1:0][2:0] mode_o,
  output logic [NPINS-1:0]      clr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int unsigned PAD = DATA_W - NPINS;

  logic                  wr, rd;
  logic [NPINS-1:0]      wbits;
  logic [NPINS-1:0]      en_q, mask_q, dout_q, dir_q;
  logic [NPINS-1:0][2:0] mode_q;
  logic [DATA_W-1:0]     mode_lo_rd, mode_hi_rd, rd_mux;
  logic [NPINS-1:0]      pin_rd;
  logic                  pin_rd_hit;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wbits = wdata_i[NPINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
    end else if (wr) begin
      case (addr_i)
        OFS_EN:      en_q   <= wbits;
        OFS_MSK_SET: mask_q <= mask_q | wbits;
        OFS_MSK_CLR: mask_q <= mask_q & ~wbits;
        OFS_DOUT:    dout_q <= wbits;
        OFS_DIR:     dir_q  <= wbits;
        default: ;
      endcase
      for (int i = 0; i < NPINS; i++) begin
        if (addr_i == ((i < PINS_PER_MODE_REG) ? OFS_MODE_LO : OFS_MODE_HI))
          mode_q[i] <= wdata_i[(i % PINS_PER_MODE_REG) * SLOT_W +: 3];
      end
    end
  end

  assign clr_o = (wr && addr_i == OFS_CLR) ? wbits : '0;

  always_comb begin
    mode_lo_rd = '0;
    mode_hi_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < PINS_PER_MODE_REG) mode_lo_rd[(i % PINS_PER_MODE_REG) * SLOT_W +: 3] = mode_q[i];
      else                       mode_hi_rd[(i % PINS_PER_MODE_REG) * SLOT_W +: 3] = mode_q[i];
    end
  end

  always_comb begin
    pin_rd_hit = 1'b1;
    pin_rd     = '0;
    case (addr_i)
      OFS_EN:      pin_rd = en_q;
      OFS_RAW:     pin_rd = raw_i;
      OFS_MASKED:  pin_rd = masked_i;
      OFS_MSK_SET: pin_rd = mask_q;
      OFS_DOUT:    pin_rd = dout_q;
      OFS_DIN:     pin_rd = din_i;
      OFS_DIR:     pin_rd = dir_q;
      default:     pin_rd_hit = 1'b0;
    endcase
    if (pin_rd_hit)                rd_mux = {{PAD{1'b0}}, pin_rd};
    else if (addr_i == OFS_MODE_LO) rd_mux = mode_lo_rd;
    else if (addr_i == OFS_MODE_HI) rd_mux = mode_hi_rd;
    else                           rd_mux = '0;
  end

  assign rdata_o = rd ? rd_mux : '0;
  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign dout_o  = dout_q;
  assign dir_o   = dir_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0]      level_w, raw_w, mask_w, en_w, clr_w, dout_w, dir_w, masked_w;
  logic [NPINS-1:0][2:0] mode_w;

  gpio_sync #(.WIDTH(NPINS)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (level_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) detect_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_w),
    .mode_i (mode_w),
    .en_i   (en_w),
    .clr_i  (clr_w),
    .raw_o  (raw_w)
  );

  gpio_irq_regs #(.NPINS(NPINS)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .din_i   (level_w),
    .raw_i   (raw_w),
    .masked_i(masked_w),
    .en_o    (en_w),
    .mask_o  (mask_w),
    .dout_o  (dout_w),
    .dir_o   (dir_w),
    .mode_o  (mode_w),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );

  assign masked_w = raw_w & ~mask_w;
  assign irq_o    = |masked_w;
  assign pin_o    = dout_w;
  assign pin_oe_o = dir_w;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [3:0]        addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [31-NPINS:0] rdata_hi_i,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  raw_i,
  input logic [NPINS-1:0]  mask_i,
  input logic [NPINS-1:0]  en_i
);
  logic wr_dir, wr_set, wr_clr, mode_addr;
  assign wr_dir    = req_i & we_i & (addr_i == OFS_DIR);
  assign wr_set    = req_i & we_i & (addr_i == OFS_MSK_SET);
  assign wr_clr    = req_i & we_i & (addr_i == OFS_MSK_CLR);
  assign mode_addr = (addr_i == OFS_MODE_LO) || (addr_i == OFS_MODE_HI);

  AST_DIR_TO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == $past(wdata_i)); // R2

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> mask_i == ($past(mask_i) | $past(wdata_i))); // R9

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> mask_i == ($past(mask_i) & ~$past(wdata_i))); // R9

  AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (raw_i & ~$past(raw_i) & ~$past(en_i)) == '0); // R7

  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_i & ~mask_i) != '0); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_addr |-> rdata_hi_i == '0); // R1
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i[NPINS-1:0]),
  .rdata_hi_i(rdata_o[31:NPINS]),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o),
  .raw_i     (raw_w),
  .mask_i    (mask_w),
  .en_i      (en_w)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  localparam int unsigned N = 12;
  localparam logic [31:0] ALL = (32'd1 << N) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [N-1:0]  pin_in = '0, pin_out, pin_oe;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port #(.NPINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk($sformatf("R12 reset read ofs %0d", a), v, 32'h0);
    end
    chk("R12 reset oe", {20'h0, pin_oe}, 32'h0);
    chk("R12 reset irq", {31'h0, irq}, 32'h0);

    // R2 direction and output latch, R1 upper bits
    wr(4'd6, 32'h0000_0A5A);
    wr(4'd8, 32'h0000_0F0F);
    chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0F0F);
    chk("R2 pin_o", {20'h0, pin_out}, 32'h0A5A);
    rd(4'd6, v); chk("R2 dout readback", v, 32'h0A5A);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v); chk("R1 dir upper bits", v, ALL);
    wr(4'd8, 32'h0);
    wr(4'd6, 32'h0);

    // R4 mode field layout
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd9, v);  chk("R4 mode lo fields", v, 32'h7777_7777);
    rd(4'd10, v); chk("R4 mode hi fields", v, 32'h0000_7777);
    wr(4'd10, 32'h0000_0250);
    rd(4'd10, v); chk("R4 mode hi slot placement", v, 32'h0000_0250);
    wr(4'd9, 32'h0);
    wr(4'd10, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R1 enable upper bits", v, ALL);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'hFFFF_FFFF);

    // R3 synchronizer latency
    @(negedge clk) pin_in = 12'h3C5;
    rd(4'd7, v); chk("R3 din after one edge", v, 32'h0);
    rd(4'd7, v); chk("R3 din after two edges", v, 32'h3C5);
    pin_in = '0;
    idle(4);

    // R7 enable gating
    wr(4'd9, 32'h0010_0000);
    @(negedge clk) pin_in[5] = 1'b1;
    idle(4);
    @(negedge clk) pin_in[5] = 1'b0;
    idle(4);
    rd(4'd1, v); chk("R7 disabled pin raw", v, 32'h0);
    chk("R7 disabled irq", {31'h0, irq}, 32'h0);

    // R8 R9 R10 mask and clear on pin 3 rising
    wr(4'd9, 32'h0000_1000);
    wr(4'd0, 32'h8);
    wr(4'd3, 32'hFFF);
    @(negedge clk) pin_in[3] = 1'b1;
    idle(4);
    rd(4'd1, v); chk("R5 rise pin3", v, 32'h8);
    wr(4'd4, 32'h8);
    rd(4'd4, v); chk("R9 mask set", v, 32'h8);
    rd(4'd2, v); chk("R10 masked hidden", v, 32'h0);
    chk("R10 irq masked low", {31'h0, irq}, 32'h0);
    rd(4'd1, v); chk("R9 raw unaffected by mask", v, 32'h8);
    wr(4'd4, 32'h0);
    rd(4'd4, v); chk("R9 zero set no effect", v, 32'h8);
    wr(4'd5, 32'h0);
    rd(4'd4, v); chk("R9 zero clear no effect", v, 32'h8);
    wr(4'd5, 32'h8);
    rd(4'd4, v); chk("R9 mask clear", v, 32'h0);
    chk("R10 irq unmasked high", {31'h0, irq}, 32'h1);
    wr(4'd3, 32'h0);
    rd(4'd1, v); chk("R8 zero clear no effect", v, 32'h8);
    wr(4'd3, 32'h8);
    rd(4'd1, v); chk("R8 w1c", v, 32'h0);
    chk("R10 irq after clear", {31'h0, irq}, 32'h0);
    wr(4'd0, 32'h0);
    @(negedge clk) pin_in = '0;
    idle(4);

    // R5 R6 R11 sweep every pin through every mode code
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [31:0] b, e;
        string tg;
        b = 32'd1 << p;
        tg = (m <= 1 || m == 4) ? "R5" : (m <= 3) ? "R6" : "R11";
        wr(4'd9,  (p < 8)  ? (32'(m) << (4 * p)) : 32'h0);
        wr(4'd10, (p >= 8) ? (32'(m) << (4 * (p - 8))) : 32'h0);
        wr(4'd0, b);
        wr(4'd3, 32'hFFFF);
        rd(4'd1, v);
        e = (m == 2) ? b : 32'h0;
        chk($sformatf("%s p%0d m%0d idle low", tg, p, m), v, e);
        @(negedge clk) pin_in[p] = 1'b1;
        idle(4);
        rd(4'd1, v);
        e = (m >= 1 && m <= 4) ? b : 32'h0;
        chk($sformatf("%s p%0d m%0d after rise", tg, p, m), v, e);
        rd(4'd2, v);
        chk($sformatf("R10 p%0d m%0d masked", p, m), v, e);
        chk($sformatf("R10 p%0d m%0d irq", p, m), {31'h0, irq}, {31'h0, e != 0});
        wr(4'd3, b);
        rd(4'd1, v);
        e = (m == 3) ? b : 32'h0;
        chk($sformatf("%s p%0d m%0d clear while high", tg, p, m), v, e);
        @(negedge clk) pin_in[p] = 1'b0;
        idle(4);
        rd(4'd1, v);
        e = (m == 0 || m == 2 || m == 3 || m == 4) ? b : 32'h0;
        chk($sformatf("%s p%0d m%0d after fall", tg, p, m), v, e);
        wr(4'd3, b);
        rd(4'd1, v);
        e = (m == 2) ? b : 32'h0;
        chk($sformatf("%s p%0d m%0d clear while low", tg, p, m), v, e);
        wr(4'd0, 32'h0);
        wr(4'd3, 32'hFFFF);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule